// File: doc/BRIEF.md
# Power-Good Window Monitor with Qualification Delay

This block decides whether a regulated output is good. It receives digitized output-voltage samples, each marked by a valid strobe. It compares every sample against a window placed around a target code. The window's upper and lower edges are set as separate percentages of the target, so the window can be asymmetric. With the usual settings the upper edge is 15 percent above the target and the lower edge is 10 percent below it.

The power-good output rises only after the conditions have held without a break for a programmable number of clock ticks. Those conditions are that the latest sample is inside the window and that no fault is flagged. Any sample outside the window, or any active fault, drops power-good at the next clock edge and restarts the qualification.

All limits and the delay arrive as plain configuration ports and may change at run time. A delay of 200000 ticks of a 200 MHz clock gives the usual 1 ms.

Top module: `pgood_monitor`

## Requirements
- R1: Once reset has been released, `pgood_o` is 0 and the qualification counter is at zero. The first qualifying sample after reset therefore starts a full delay.
- R2: The upper bound is floor(target*(100+up_pct)/100), computed at full width so that it may exceed the sample range. A sample equal to the upper bound is inside the window.
- R3: The lower bound is floor(target*(100-down_pct)/100). It is 0 when down_pct is 100 or more. A sample equal to the lower bound is inside the window.
- R4: The bounds follow `target_i`, `up_pct_i` and `down_pct_i` without any latency. A sample is judged against the configuration present in the same cycle.
- R5: A valid sample outside the window drives `pgood_o` to 0 after that clock edge and clears the counter.
- R6: While `fault_i` is 1 at a clock edge, `pgood_o` is 0 after that edge. The counter is cleared, and so is the qualified state: a new in-window valid sample is needed before counting resumes.
- R7: Call the clock edge of the first qualifying sample edge 0. With delay D and the conditions held, `pgood_o` becomes 1 after edge D. When D is 0, it asserts on the first qualifying sample.
- R8: In cycles without a valid strobe, the verdict of the last valid sample stands and counting continues. Before any valid sample, the block is not qualified.
- R9: If `delay_i` is lowered below the count already reached, `pgood_o` asserts at the next qualifying edge.
- R10: Reset is synchronous and active low. A reset edge forces `pgood_o` to 0 even while it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | CODE_W | Digitized output-voltage code |
| sample_vld_i | input | 1 | Marks `sample_i` as a new sample |
| target_i | input | CODE_W | Target output code |
| up_pct_i | input | PCT_W | Upper limit, in percent above target |
| down_pct_i | input | PCT_W | Lower limit, in percent below target |
| delay_i | input | DLY_W | Qualification delay in clock ticks |
| fault_i | input | 1 | Any active fault; vetoes power-good |
| pgood_o | output | 1 | Registered power-good level |

## Verification
The window is tested with a zero delay. Every sample code is swept against several targets and several limit pairs: the usual 15/10 pair, a zero-width window, and limits beyond 100 percent. This sweep separates an off-by-one or exclusive bound, a truncation error and a lower-limit underflow. Sequences with a nonzero delay then test four cases in turn: continuous qualifying samples, an interruption by an out-of-window sample, a fault veto, and gaps in the valid strobe. Together these separate an early or late rise from a counter that is not cleared or a qualification that is kept too long. Further sequences lower the delay mid-count, move the target under a fixed sample, and apply reset while power-good is high.

// File: rtl/pg_pkg.sv
// Package pg_pkg: shared constants and bound arithmetic for the power-good monitor.
// Assumes percentages are unsigned and that bounds are evaluated at a width wide
// enough to hold target*(100+max_pct) without loss.
package pg_pkg;

    localparam int unsigned PCT_SCALE = 100;

    // Scale a code by (100+pct)/100 or (100-pct)/100 with floor division.
    function automatic logic [31:0] pct_scale(input logic [31:0] code,
                                              input logic [31:0] pct,
                                              input logic        above);
        logic [31:0] factor;
        if (above)
            factor = PCT_SCALE + pct;
        else if (pct >= PCT_SCALE)
            factor = 32'd0;
        else
            factor = PCT_SCALE - pct;
        return (code * factor) / PCT_SCALE;
    endfunction

endpackage

// File: rtl/pg_window.sv
// Module pg_window: derives the window bounds from the target and the two
// percentage limits, and flags whether the current sample lies inside them.
// Assumes the configuration is static for at least the cycle it is used in;
// the bounds are purely combinational so any change applies at once.
module pg_window #(
    parameter int CODE_W = 8,
    parameter int PCT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] sample_i,
    input  logic [CODE_W-1:0] target_i,
    input  logic [PCT_W-1:0]  up_pct_i,
    input  logic [PCT_W-1:0]  down_pct_i,
    output logic              in_win_o
);
    import pg_pkg::*;

    localparam int BND_W = CODE_W + PCT_W + 1;

    logic [BND_W-1:0] hi_bnd;
    logic [BND_W-1:0] lo_bnd;
    logic [31:0]      hi_full;
    logic [31:0]      lo_full;

    // Compute the upper and lower bounds from the current configuration.
    always_comb begin
        hi_full = pct_scale(32'(target_i), 32'(up_pct_i), 1'b1);
        lo_full = pct_scale(32'(target_i), 32'(down_pct_i), 1'b0);
        hi_bnd  = hi_full[BND_W-1:0];
        lo_bnd  = lo_full[BND_W-1:0];
    end

    // Inclusive window comparison at full bound width.
    always_comb begin
        in_win_o = (BND_W'(sample_i) >= lo_bnd) && (BND_W'(sample_i) <= hi_bnd);
    end

    // R2/R3: the target itself always sits between the two bounds.
    assert_bounds_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_bnd <= BND_W'(target_i)) && (BND_W'(target_i) <= hi_bnd));

    // R3: a lower limit of 100 percent or more opens the window down to zero.
    assert_lo_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(down_pct_i) >= 32'd100) |-> in_win_o == (BND_W'(sample_i) <= hi_bnd));

endmodule

// File: rtl/pg_qualify.sv
// Module pg_qualify: tracks whether the conditions for power-good hold, counts
// ticks while they do, and registers the power-good level once the delay is met.
// Assumes in_win_i is the verdict for the sample presented in the same cycle.
module pg_qualify #(
    parameter int DLY_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             in_win_i,
    input  logic             fault_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             pgood_o
);
    logic             qual_q;
    logic [DLY_W-1:0] cnt_q;
    logic             ok_now;

    // Conditions met this cycle: no fault, and the newest verdict is in-window.
    always_comb begin
        ok_now = !fault_i && (vld_i ? in_win_i : qual_q);
    end

    // Qualification state, delay counter and registered power-good level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q  <= 1'b0;
            cnt_q   <= '0;
            pgood_o <= 1'b0;
        end else if (!ok_now) begin
            qual_q  <= 1'b0;
            cnt_q   <= '0;
            pgood_o <= 1'b0;
        end else begin
            qual_q <= 1'b1;
            if (cnt_q >= delay_i)
                pgood_o <= 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: any fault at an edge leaves power-good low afterwards.
    assert_fault_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !pgood_o);

    // R5: a valid out-of-window sample drops power-good and the count.
    assert_out_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !in_win_i) |=> (!pgood_o && cnt_q == '0));

    // R7: power-good only rises once the count has reached the delay.
    assert_rise_after_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood_o) |-> ($past(cnt_q) >= $past(delay_i) && !$past(fault_i)));

    // R10: a reset edge always leaves power-good low.
    assert_reset_low_R10: assert property (@(posedge clk)
        !rst_n |=> !pgood_o);

endmodule

// File: rtl/pgood_monitor.sv
// Module pgood_monitor: top of the power-good window monitor. Joins the window
// comparator with the delay qualifier. Assumes configuration ports are driven
// from stable registers and samples are marked by a one-cycle valid strobe.
module pgood_monitor #(
    parameter int CODE_W = 8,
    parameter int PCT_W  = 8,
    parameter int DLY_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] sample_i,
    input  logic              sample_vld_i,
    input  logic [CODE_W-1:0] target_i,
    input  logic [PCT_W-1:0]  up_pct_i,
    input  logic [PCT_W-1:0]  down_pct_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic              fault_i,
    output logic              pgood_o
);
    logic in_win;

    pg_window #(.CODE_W(CODE_W), .PCT_W(PCT_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_i),
        .target_i  (target_i),
        .up_pct_i  (up_pct_i),
        .down_pct_i(down_pct_i),
        .in_win_o  (in_win)
    );

    pg_qualify #(.DLY_W(DLY_W)) u_qualify (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (sample_vld_i),
        .in_win_i(in_win),
        .fault_i (fault_i),
        .delay_i (delay_i),
        .pgood_o (pgood_o)
    );

endmodule

// File: tb/tb_pgood_monitor.sv
module tb_pgood_monitor;

    localparam int CODE_W = 8;
    localparam int PCT_W  = 8;
    localparam int DLY_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CODE_W-1:0] sample;
    logic              vld;
    logic [CODE_W-1:0] target;
    logic [PCT_W-1:0]  up_pct;
    logic [PCT_W-1:0]  down_pct;
    logic [DLY_W-1:0]  delay;
    logic              fault;
    logic              pgood;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pgood_monitor #(.CODE_W(CODE_W), .PCT_W(PCT_W), .DLY_W(DLY_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample),
        .sample_vld_i(vld),
        .target_i    (target),
        .up_pct_i    (up_pct),
        .down_pct_i  (down_pct),
        .delay_i     (delay),
        .fault_i     (fault),
        .pgood_o     (pgood)
    );

    function automatic int exp_hi(int t, int u);
        return (t * (100 + u)) / 100;
    endfunction

    function automatic int exp_lo(int t, int d);
        return (d >= 100) ? 0 : (t * (100 - d)) / 100;
    endfunction

    task automatic check(input string req, input logic exp);
        n_tests++;
        if (pgood !== exp) begin
            n_fail++;
            $display("FAIL %s: pgood=%0b expected=%0b (t=%0t)", req, pgood, exp, $time);
        end
    endtask

    // Drive inputs at the falling edge, then sample just after the rising edge.
    task automatic step(input logic v, input int s, input logic f);
        @(negedge clk);
        vld    = v;
        sample = CODE_W'(s);
        fault  = f;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vld   = 1'b0;
        fault = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: expired before completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int tl [7];
        int ul [4];
        int dl [4];
        rst_n = 1'b0; sample = '0; vld = 1'b0; target = 8'd100;
        up_pct = 8'd15; down_pct = 8'd10; delay = '0; fault = 1'b0;
        tl = '{0, 1, 99, 100, 160, 200, 255};
        ul = '{15, 0, 50, 255};
        dl = '{10, 0, 100, 200};

        do_reset();
        // R1: power-good low out of reset, and no qualification without samples (R8)
        check("R1", 1'b0);
        delay = 20'd3;
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 100, 1'b0);
            check("R8", 1'b0);
        end

        // R2/R3: exhaustive sample sweep with zero delay (R7 zero-delay case)
        delay = '0;
        for (int ti = 0; ti < 7; ti++) begin
            for (int ci = 0; ci < 4; ci++) begin
                @(negedge clk);
                target = CODE_W'(tl[ti]); up_pct = PCT_W'(ul[ci]); down_pct = PCT_W'(dl[ci]);
                for (int s = 0; s < 256; s++) begin
                    step(1'b1, s, 1'b0);
                    if (s > exp_hi(tl[ti], ul[ci]))
                        check("R2", 1'b0);
                    else if (s < exp_lo(tl[ti], dl[ci]))
                        check("R3", 1'b0);
                    else
                        check("R7", 1'b1);
                end
            end
        end

        // R1/R7: after reset the count starts at zero; delay 5 rises after edge 5
        target = 8'd100; up_pct = 8'd15; down_pct = 8'd10; delay = 20'd5;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 115, 1'b0);
            check("R7", i >= 5);
        end
        // R5: out-of-window sample drops power-good, count restarts
        step(1'b1, 116, 1'b0);
        check("R5", 1'b0);
        for (int i = 0; i < 7; i++) begin
            step(1'b1, 90, 1'b0);
            check("R5", i >= 5);
        end
        // R6: fault vetoes even with an in-window sample
        step(1'b1, 100, 1'b1);
        check("R6", 1'b0);
        // R6: after the fault, idle cycles do not requalify
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 100, 1'b0);
            check("R6", 1'b0);
        end
        // R8: one in-window sample then idle cycles keep counting
        step(1'b1, 100, 1'b0);
        check("R8", 1'b0);
        for (int i = 1; i < 8; i++) begin
            step(1'b0, 0, 1'b0);
            check("R8", i >= 5);
        end
        // R6: fault without a valid sample also drops power-good
        step(1'b0, 0, 1'b1);
        check("R6", 1'b0);

        // R9: lower the delay below the count reached
        delay = 20'd20;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 100, 1'b0);
            check("R9", 1'b0);
        end
        @(negedge clk);
        delay = 20'd3;
        step(1'b1, 100, 1'b0);
        check("R9", 1'b1);

        // R4: moving the target under a fixed sample applies at once
        @(negedge clk);
        target = 8'd200;
        step(1'b1, 100, 1'b0);
        check("R4", 1'b0);
        @(negedge clk);
        target = 8'd100; delay = '0;
        step(1'b1, 100, 1'b0);
        check("R4", 1'b1);
        @(negedge clk);
        up_pct = 8'd0; down_pct = 8'd0;
        step(1'b1, 101, 1'b0);
        check("R4", 1'b0);

        // R10: reset while power-good is high
        step(1'b1, 100, 1'b0);
        check("R10", 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule